// File: doc/BRIEF.md
# Display Power-On Command Sequencer

This block brings a small serially driven OLED panel out of power-up. After system reset it raises the panel's logic and high-voltage enables and holds the panel reset low for a set number of clocks. It then waits a settle time and shifts a fixed list of command records into the panel controller over a four-wire serial link. After a final wait it raises a done flag. The command records are not held in logic. They sit at the bottom of a synchronous-read memory that is preloaded at configuration.

Each record is stored as a count byte (1 to 5) followed by that many command bytes. A count of zero ends the list. Once the sequence is over, a 2:1 multiplexer hands the memory's read address to a downstream user. That user then reads the same memory, including the data placed above the command table, through the block's user port. The block runs only once per reset.

Top module: `oled_power_seq`

## Requirements
- R1: While reset is asserted: init_done=0, spi_cs_n=1, spi_sclk=0, pnl_rst_n=0, pnl_logic_en=0 and pnl_hv_en=0.
- R2: After reset is released, pnl_rst_n stays low for exactly RST_LOW_CYC clock cycles. It then goes high and stays high until the next reset.
- R3: pnl_logic_en and pnl_hv_en go high on the first clock after reset release and stay high until the next reset.
- R4: At least PRE_CMD_CYC clock cycles pass between pnl_rst_n rising and the first fall of spi_cs_n.
- R5: Records are sent in memory order starting at address 0. Each record takes one low period of spi_cs_n and carries exactly its count of bytes (count byte first, values 1 to 5). A count byte of 0 ends the sequence, and nothing after it is sent. spi_cs_n is never low unless a byte is being sent.
- R6: Bytes go out most significant bit first. spi_dc is low throughout. spi_sclk idles low. spi_mosi changes only while spi_sclk is low and is stable across every high phase.
- R7: Every high phase of spi_sclk lasts exactly CLK_HALF system clocks.
- R8: init_done rises no sooner than POST_CMD_CYC clocks after the last rise of spi_cs_n and stays high until the next reset.
- R9: While init_done is low, usr_addr has no effect on the command stream. Once init_done is high, usr_rdata equals the memory word at usr_addr one clock after the address is presented.
- R10: After init_done is high, spi_cs_n stays high and spi_sclk stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | output | 1 | Serial clock to the panel, idles low |
| spi_mosi | output | 1 | Serial data, MSB first |
| spi_cs_n | output | 1 | Chip select, low for one whole record |
| spi_dc | output | 1 | Data/command select, held low (command) |
| pnl_rst_n | output | 1 | Panel reset, active low |
| pnl_logic_en | output | 1 | Panel logic supply enable |
| pnl_hv_en | output | 1 | Panel high-voltage supply enable |
| init_done | output | 1 | Sticky flag: power-up sequence finished |
| usr_addr | input | AW | Read address from the post-init user |
| usr_rdata | output | 8 | Memory read data, one-clock latency |

## Verification
The bench sends records of every length from one to five bytes. It checks the byte order and per-frame byte count against its own copy of the table. A sequencer that ignored the memory's read latency would send each byte one slot late, or send the count byte as data. A zero count that failed to stop the walk would produce extra frames. While the sequence runs, the bench toggles the user address. If the multiplexer selected the wrong source, the stream would be corrupted. The bench measures the length of the reset pulse, the pre-command gap, the post-command gap and the width of each clock-high phase, so an off-by-one in any counter shows up. A reset in the middle of a frame must return every output to its idle value, and the next run must produce the full frame count again.

// File: rtl/oled_seq_pkg.sv
package oled_seq_pkg;

   typedef enum logic [3:0] {
      ST_RST,
      ST_SETTLE,
      ST_FLEN,
      ST_LEN,
      ST_FBYTE,
      ST_LOAD,
      ST_SHIFT,
      ST_TAIL,
      ST_DONE
   } seq_state_t;

   // Configuration-time memory image: length-prefixed command records, a
   // zero terminator, then a fill pattern for the post-init user.
   function automatic logic [7:0] boot_byte(input int a);
      logic [7:0] v;
      case (a)
         0:  v = 8'h01;  1:  v = 8'hAE;
         2:  v = 8'h02;  3:  v = 8'hA0;  4:  v = 8'h72;
         5:  v = 8'h03;  6:  v = 8'h15;  7:  v = 8'h00;  8:  v = 8'h5F;
         9:  v = 8'h04;  10: v = 8'h81;  11: v = 8'h91;  12: v = 8'h50; 13: v = 8'h7D;
         14: v = 8'h05;  15: v = 8'h8A;  16: v = 8'h61;  17: v = 8'h62; 18: v = 8'h63; 19: v = 8'h64;
         20: v = 8'h01;  21: v = 8'hAF;
         22: v = 8'h00;
         default: v = 8'(a) ^ 8'h5A;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/oled_cmd_mem.sv
module oled_cmd_mem #(
   parameter int DEPTH = 512,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic [AW-1:0] addr,
   output logic [7:0]    rdata
);
   import oled_seq_pkg::*;

   generate
      if (DEPTH < 32 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("oled_cmd_mem: DEPTH must be a power of two and at least 32");
      end
   endgenerate

   logic [7:0] store [DEPTH];

   initial begin
      for (int i = 0; i < DEPTH; i++) store[i] = boot_byte(i);
   end

   always_ff @(posedge clk) begin
      rdata <= store[addr];
   end

endmodule

// File: rtl/oled_spi_tx.sv
module oled_spi_tx #(
   parameter int CLK_HALF = 2,
   localparam int DW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] din,
   output logic       sclk,
   output logic       mosi,
   output logic       busy,
   output logic       fin
);

   generate
      if (CLK_HALF < 1) begin : g_bad_half
         $error("oled_spi_tx: CLK_HALF must be at least 1");
      end
   endgenerate

   logic [7:0]    sh;
   logic [3:0]    bits_left;
   logic [DW-1:0] div;

   assign mosi = sh[7];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh        <= '0;
         bits_left <= '0;
         div       <= '0;
         sclk      <= 1'b0;
         busy      <= 1'b0;
         fin       <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (!busy) begin
            if (start) begin
               sh        <= din;
               bits_left <= 4'd8;
               div       <= '0;
               sclk      <= 1'b0;
               busy      <= 1'b1;
            end
         end else if (div == DW'(CLK_HALF - 1)) begin
            div <= '0;
            if (!sclk) begin
               sclk <= 1'b1;
            end else begin
               sclk <= 1'b0;
               if (bits_left == 4'd1) begin
                  busy <= 1'b0;
                  fin  <= 1'b1;
               end else begin
                  sh        <= {sh[6:0], 1'b0};
                  bits_left <= bits_left - 4'd1;
               end
            end
         end else begin
            div <= div + DW'(1);
         end
      end
   end

   // R6: data holds while the serial clock is high
   a_r6_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(mosi));
   // R6: data does not move on the rising edge
   a_r6_mosi_stable_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |-> $stable(mosi));
   // R6: clock idles low between bytes
   a_r6_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sclk);

endmodule

// File: rtl/oled_seq_fsm.sv
module oled_seq_fsm #(
   parameter int AW           = 9,
   parameter int RST_LOW_CYC  = 20,
   parameter int PRE_CMD_CYC  = 30,
   parameter int POST_CMD_CYC = 25,
   localparam int MAXD = (RST_LOW_CYC > PRE_CMD_CYC)
                         ? ((RST_LOW_CYC > POST_CMD_CYC) ? RST_LOW_CYC : POST_CMD_CYC)
                         : ((PRE_CMD_CYC > POST_CMD_CYC) ? PRE_CMD_CYC : POST_CMD_CYC),
   localparam int CW = $clog2(MAXD + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [7:0]    rd,
   output logic [AW-1:0] seq_addr,
   output logic          tx_start,
   input  logic          tx_fin,
   output logic          cs_n,
   output logic          pnl_rst_n,
   output logic          pwr_en,
   output logic          done
);
   import oled_seq_pkg::*;

   generate
      if (RST_LOW_CYC < 1 || PRE_CMD_CYC < 1 || POST_CMD_CYC < 1) begin : g_bad_delay
         $error("oled_seq_fsm: every delay must be at least one cycle");
      end
   endgenerate

   seq_state_t    st;
   logic [CW-1:0] tmr;
   logic [AW-1:0] ptr;
   logic [2:0]    left;

   assign seq_addr  = ptr;
   assign tx_start  = (st == ST_LOAD);
   assign pnl_rst_n = (st != ST_RST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_RST;
         tmr    <= '0;
         ptr    <= '0;
         left   <= '0;
         cs_n   <= 1'b1;
         pwr_en <= 1'b0;
         done   <= 1'b0;
      end else begin
         pwr_en <= 1'b1;
         case (st)
            ST_RST: begin
               if (tmr == CW'(RST_LOW_CYC - 1)) begin
                  tmr <= '0;
                  st  <= ST_SETTLE;
               end else tmr <= tmr + CW'(1);
            end
            ST_SETTLE: begin
               if (tmr == CW'(PRE_CMD_CYC - 1)) begin
                  tmr <= '0;
                  st  <= ST_FLEN;
               end else tmr <= tmr + CW'(1);
            end
            ST_FLEN: st <= ST_LEN;        // count address issued, data next cycle
            ST_LEN: begin
               if (rd == 8'd0) begin
                  st <= ST_TAIL;
               end else begin
                  left <= rd[2:0];
                  ptr  <= ptr + AW'(1);
                  cs_n <= 1'b0;
                  st   <= ST_FBYTE;
               end
            end
            ST_FBYTE: st <= ST_LOAD;      // byte address issued, data next cycle
            ST_LOAD: begin
               ptr <= ptr + AW'(1);
               st  <= ST_SHIFT;
            end
            ST_SHIFT: begin
               if (tx_fin) begin
                  if (left == 3'd1) begin
                     cs_n <= 1'b1;
                     st   <= ST_FLEN;
                  end else begin
                     left <= left - 3'd1;
                     st   <= ST_FBYTE;
                  end
               end
            end
            ST_TAIL: begin
               if (tmr == CW'(POST_CMD_CYC - 1)) begin
                  done <= 1'b1;
                  st   <= ST_DONE;
               end else tmr <= tmr + CW'(1);
            end
            default: st <= ST_DONE;
         endcase
      end
   end

   // R8: done is sticky
   a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $past(done) |-> done);
   // R2: panel reset never drops again before the next system reset
   a_r2_rst_stays_high: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pnl_rst_n) |-> pnl_rst_n);
   // R3: supplies stay on
   a_r3_en_stays_high: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pwr_en) |-> pwr_en);
   // R10: no select activity once done
   a_r10_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> cs_n);
   // R5: record count within the legal range when a record starts
   a_r5_count_range: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_LEN && rd != 8'd0) |-> (rd <= 8'd5));

endmodule

// File: rtl/oled_power_seq.sv
module oled_power_seq #(
   parameter int DEPTH        = 512,
   parameter int CLK_HALF     = 2,
   parameter int RST_LOW_CYC  = 20,
   parameter int PRE_CMD_CYC  = 30,
   parameter int POST_CMD_CYC = 25,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic          spi_sclk,
   output logic          spi_mosi,
   output logic          spi_cs_n,
   output logic          spi_dc,
   output logic          pnl_rst_n,
   output logic          pnl_logic_en,
   output logic          pnl_hv_en,
   output logic          init_done,
   input  logic [AW-1:0] usr_addr,
   output logic [7:0]    usr_rdata
);

   logic [AW-1:0] seq_addr;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_rd;
   logic          tx_start;
   logic          tx_fin;
   logic          tx_busy;
   logic          pwr_en;

   // 2:1 read-address select: sequencer until done, then the user
   assign mem_addr = init_done ? usr_addr : seq_addr;

   oled_cmd_mem #(.DEPTH(DEPTH)) u_mem (
      .clk   (clk),
      .addr  (mem_addr),
      .rdata (mem_rd)
   );

   oled_seq_fsm #(
      .AW           (AW),
      .RST_LOW_CYC  (RST_LOW_CYC),
      .PRE_CMD_CYC  (PRE_CMD_CYC),
      .POST_CMD_CYC (POST_CMD_CYC)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd        (mem_rd),
      .seq_addr  (seq_addr),
      .tx_start  (tx_start),
      .tx_fin    (tx_fin),
      .cs_n      (spi_cs_n),
      .pnl_rst_n (pnl_rst_n),
      .pwr_en    (pwr_en),
      .done      (init_done)
   );

   oled_spi_tx #(.CLK_HALF(CLK_HALF)) u_tx (
      .clk   (clk),
      .rst_n (rst_n),
      .start (tx_start),
      .din   (mem_rd),
      .sclk  (spi_sclk),
      .mosi  (spi_mosi),
      .busy  (tx_busy),
      .fin   (tx_fin)
   );

   assign spi_dc       = 1'b0;
   assign pnl_logic_en = pwr_en;
   assign pnl_hv_en    = pwr_en;
   assign usr_rdata    = mem_rd;

   // R5: a byte is only shifted while the panel is selected
   a_r5_busy_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
      tx_busy |-> !spi_cs_n);
   // R10: serial clock low whenever select is released
   a_r10_sclk_low_unselected: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sclk);

endmodule

// File: tb/sim_oled_power_seq.sv
`timescale 1ns/1ps
module sim_oled_power_seq;

   localparam int DEPTH = 512;
   localparam int AW    = 9;
   localparam int HALF  = 2;
   localparam int RLOW  = 20;
   localparam int PRE   = 30;
   localparam int POST  = 25;
   localparam int NREC  = 6;

   // expected records: element 0 is the count, then the bytes
   localparam logic [7:0] EXP [NREC][6] = '{
      '{8'd1, 8'hAE, 8'h00, 8'h00, 8'h00, 8'h00},
      '{8'd2, 8'hA0, 8'h72, 8'h00, 8'h00, 8'h00},
      '{8'd3, 8'h15, 8'h00, 8'h5F, 8'h00, 8'h00},
      '{8'd4, 8'h81, 8'h91, 8'h50, 8'h7D, 8'h00},
      '{8'd5, 8'h8A, 8'h61, 8'h62, 8'h63, 8'h64},
      '{8'd1, 8'hAF, 8'h00, 8'h00, 8'h00, 8'h00}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] usr_addr = '0;
   logic spi_sclk, spi_mosi, spi_cs_n, spi_dc;
   logic pnl_rst_n, pnl_logic_en, pnl_hv_en, init_done;
   logic [7:0] usr_rdata;

   int tests = 0;
   int fails = 0;

   always #2 clk = ~clk;

   oled_power_seq #(
      .DEPTH(DEPTH), .CLK_HALF(HALF), .RST_LOW_CYC(RLOW),
      .PRE_CMD_CYC(PRE), .POST_CMD_CYC(POST)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
      .spi_cs_n(spi_cs_n), .spi_dc(spi_dc), .pnl_rst_n(pnl_rst_n),
      .pnl_logic_en(pnl_logic_en), .pnl_hv_en(pnl_hv_en), .init_done(init_done),
      .usr_addr(usr_addr), .usr_rdata(usr_rdata)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // monitor, sampling at the falling system clock edge
   int cyc = 0;
   int nfr = 0, nb = 0, bitc = 0, hi_cnt = 0;
   int bad_hi = 0, bad_dc = 0, bad_part = 0, bad_mosi = 0, post_done_act = 0;
   int rst_rise = -1, cs_first = -1, cs_last = -1, done_rise = -1;
   int flen [16];
   logic [7:0] rxb [64];
   logic [7:0] sh = '0;
   logic p_sclk = 1'b0, p_cs = 1'b1, p_rst = 1'b0, p_done = 1'b0, p_mosi = 1'b0;

   always @(negedge clk) begin
      cyc++;
      if (!rst_n) begin
         nfr = 0; nb = 0; bitc = 0; hi_cnt = 0;
         rst_rise = -1; cs_first = -1; cs_last = -1; done_rise = -1;
         p_sclk = 1'b0; p_cs = 1'b1; p_rst = 1'b0; p_done = 1'b0;
      end else begin
         if (!p_rst && pnl_rst_n) rst_rise = cyc;
         if (p_cs && !spi_cs_n) begin
            if (cs_first < 0) cs_first = cyc;
            if (nfr < 16) flen[nfr] = 0;
         end
         if (spi_dc !== 1'b0) bad_dc++;
         if (p_sclk && spi_sclk && (spi_mosi !== p_mosi)) bad_mosi++;
         if (!p_sclk && spi_sclk) begin
            if (spi_mosi !== p_mosi) bad_mosi++;
            sh = {sh[6:0], spi_mosi};
            bitc++;
            if (bitc == 8) begin
               if (nb < 64) rxb[nb] = sh;
               nb++;
               if (nfr < 16) flen[nfr]++;
               bitc = 0;
            end
         end
         if (spi_sclk) hi_cnt++;
         if (p_sclk && !spi_sclk) begin
            if (hi_cnt != HALF) bad_hi++;
            hi_cnt = 0;
         end
         if (!p_cs && spi_cs_n) begin
            if (bitc != 0) bad_part++;
            nfr++;
            cs_last = cyc;
         end
         if (p_done && (!spi_cs_n || spi_sclk)) post_done_act++;
         if (!p_done && init_done) done_rise = cyc;
         p_sclk = spi_sclk; p_cs = spi_cs_n; p_rst = pnl_rst_n;
         p_done = init_done; p_mosi = spi_mosi;
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int lo;
      int idx;
      logic ok;

      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 done", init_done, 0);
      check("R1 cs_n", spi_cs_n, 1);
      check("R1 sclk", spi_sclk, 0);
      check("R1 pnl_rst_n", pnl_rst_n, 0);
      check("R1 enables", {pnl_logic_en, pnl_hv_en}, 2'b00);

      rst_n = 1'b1;
      lo = 0;
      while (pnl_rst_n == 1'b0) begin
         lo++;
         if (lo == 2) check("R3 enables on after release", {pnl_logic_en, pnl_hv_en}, 2'b11);
         @(negedge clk);
      end
      check("R2 reset low length", lo, RLOW);

      // R9: wiggle the user address while the sequence runs
      while (!init_done) begin
         usr_addr = usr_addr + 9'd37;
         @(negedge clk);
      end
      @(negedge clk);

      check("R4 pre-command gap", (cs_first - rst_rise) >= PRE, 1);
      check("R5 frame count", nfr, NREC);

      // R5 R6 R9: walk the expected record table
      idx = 0;
      for (int r = 0; r < NREC; r++) begin
         ok = (flen[r] == int'(EXP[r][0]));
         for (int b = 1; b <= int'(EXP[r][0]); b++) begin
            if (rxb[idx] !== EXP[r][b]) ok = 1'b0;
            idx++;
         end
         check($sformatf("R5/R6/R9 record %0d", r), ok, 1);
      end
      check("R5 no partial byte", bad_part, 0);
      check("R6 dc low", bad_dc, 0);
      check("R6 mosi stable over high phase", bad_mosi, 0);
      check("R7 high phase width", bad_hi, 0);
      check("R8 post gap", (done_rise - cs_last) >= POST, 1);
      check("R3 enables still on", {pnl_logic_en, pnl_hv_en}, 2'b11);
      check("R2 reset still high", pnl_rst_n, 1);

      // R9: user reads after done, one-cycle latency
      usr_addr = 9'd1;   @(negedge clk); check("R9 read addr 1", usr_rdata, 8'hAE);
      usr_addr = 9'd22;  @(negedge clk); check("R9 read terminator", usr_rdata, 8'h00);
      usr_addr = 9'd300; @(negedge clk); check("R9 read addr 300", usr_rdata, 8'((300 & 255) ^ 8'h5A));
      usr_addr = 9'd511; @(negedge clk); check("R9 read addr 511", usr_rdata, 8'hA5);

      repeat (40) @(negedge clk);
      check("R8 done sticky", init_done, 1);
      check("R10 quiet after done", post_done_act, 0);

      // R1: reset in the middle of a frame
      rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
      while (spi_cs_n) @(negedge clk);
      repeat (7) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 mid-frame reset outputs",
            {init_done, spi_cs_n, spi_sclk, pnl_rst_n, pnl_logic_en, pnl_hv_en}, 6'b010000);
      @(negedge clk);
      rst_n = 1'b1;
      while (!init_done) @(negedge clk);
      @(negedge clk);
      check("R5 rerun frame count", nfr, NREC);
      check("R8 rerun done", init_done, 1);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule